// File: doc/BRIEF.md
# Chroma Quadrature Demodulator

This block turns a stream of 9-bit signed chroma samples into two baseband color-difference channels. A phase accumulator advances by a programmable increment on every accepted sample. The upper bits of that accumulator select a point on a computed sine wave, which yields an in-phase carrier and a quadrature carrier a quarter period apart. Each carrier multiplies the incoming sample. The product is rounded back to 9 bits and passed to a moving-average low-pass filter.

The increment word sets the subcarrier frequency for the color standard in use. A 2-bit select chooses one of four averaging lengths, and both channels use the same length. A small controller tracks how many samples have entered the current window. It has two states. `ST_FILL` (collecting) moves to `ST_RUN` on the sample that completes the window. `ST_RUN` returns to `ST_FILL` on any change of the select. A reset also leaves the controller in `ST_FILL`.

Top module: `chroma_qdemod`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and out_u and out_v are 0. The phase accumulator and the sample history are both cleared to zero.
- R2: The 24-bit phase accumulator starts at 0. Each accepted sample (in_valid=1) is mixed at the current phase, and the accumulator then adds phase_inc modulo 2^24. Without in_valid the accumulator holds its value. The lookup address a is the accumulator bits [23:16].
- R3: The carrier value for an address a is computed as follows. Let k = a mod 128 and m = floor(k*(128-k)*255/4096). The value is m when a<128 and -m otherwise. The quadrature carrier uses address a. The in-phase carrier uses address (a+64) mod 256. At least one of the two carriers is always nonzero.
- R4: Each product p = sample*carrier is reduced to floor((p+128)/256) and then clamped to the range [-255, +255]. out_u is derived from the in-phase product and out_v from the quadrature product.
- R5: lpf_sel encodes the window length N: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. The output is floor(S/N), where S is the sum of the N most recent mixed samples (older slots hold their last value or zero after reset). The output lies within [-255, +255].
- R6: A sample accepted in cycle t updates out_u and out_v after the next edge. out_valid rises for that one cycle only if at least N samples, this one included, have been accepted since the last restart.
- R7: Reset, or a cycle in which lpf_sel differs from its value in the previous cycle (0 is assumed before the first cycle), restarts the fill count. A sample accepted in that cycle counts as the first of the new window, so out_valid stays 0 in the next cycle.
- R8: In a cycle without in_valid, out_valid is 0 in the next cycle and out_u and out_v keep their values.
- R9: The controller stays in ST_FILL until the fill count reaches N, and it reports valid samples only once in ST_RUN. A change of lpf_sel while in ST_RUN sends it back to ST_FILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chroma sample present this cycle |
| in_chroma | input | 9 | Signed chroma sample |
| phase_inc | input | 24 | Phase increment per accepted sample |
| lpf_sel | input | 2 | Averaging length select |
| out_valid | output | 1 | Filtered pair valid |
| out_u | output | 9 | Signed in-phase channel |
| out_v | output | 9 | Signed quadrature channel |

## Verification
The first test feeds a constant sample with a zero increment. This isolates the mixer and rounding at a fixed carrier pair, so a swapped carrier or an offset in the rounding shows at once. Single-step increments followed by random large increments then walk the whole carrier table. Full-scale negative samples exercise the signed product extremes. Random samples at each of the four select codes tell the window lengths and their divisors apart. Select changes with and without a sample in the same cycle, together with gapped valid patterns, separate the restart, the fill count and the hold behaviour.

// File: rtl/qdm_pkg.sv
package qdm_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } qdm_state_e;
endpackage

// File: rtl/qdm_dto.sv
module qdm_dto #(
    parameter int ACC_W  = 24,
    parameter int LUT_W  = 8,
    parameter int DATA_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic [ACC_W-1:0]         inc,
    output logic signed [DATA_W-1:0] car_i,
    output logic signed [DATA_W-1:0] car_q
);
    localparam int HALF = 1 << (LUT_W - 1);
    localparam int QTR  = 1 << (LUT_W - 2);
    localparam int AMP  = (1 << (DATA_W - 1)) - 1;
    localparam int SH   = 2 * (LUT_W - 2);

    logic [ACC_W-1:0] acc_q;
    logic [LUT_W-1:0] addr_q;
    logic [LUT_W-1:0] addr_i;

    function automatic logic signed [DATA_W-1:0] wave(input logic [LUT_W-1:0] a);
        int k;
        int mag;
        k   = int'(a[LUT_W-2:0]);
        mag = (k * (HALF - k) * AMP) >>> SH;
        wave = a[LUT_W-1] ? DATA_W'(-mag) : DATA_W'(mag);
    endfunction

    assign addr_q = acc_q[ACC_W-1 -: LUT_W];
    assign addr_i = addr_q + LUT_W'(QTR);
    assign car_q  = wave(addr_q);
    assign car_i  = wave(addr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_q + inc;
        end
    end

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc_q));

    assert_carrier_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (car_i != '0) || (car_q != '0));
endmodule

// File: rtl/qdm_mix.sv
module qdm_mix #(
    parameter int DATA_W = 9
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] c,
    output logic signed [DATA_W-1:0] y
);
    localparam int PW    = 2 * DATA_W;
    localparam int SHIFT = DATA_W - 1;
    localparam int MAXV  = (1 << (DATA_W - 1)) - 1;
    localparam logic signed [PW-1:0] RND = PW'(1) << (SHIFT - 1);
    localparam logic signed [PW-1:0] HI  = PW'(MAXV);
    localparam logic signed [PW-1:0] LO  = -HI;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        prod = x * c;
        rnd  = (prod + RND) >>> SHIFT;
        if (rnd > HI) begin
            y = DATA_W'(MAXV);
        end else if (rnd < LO) begin
            y = -DATA_W'(MAXV);
        end else begin
            y = rnd[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/qdm_avg.sv
module qdm_avg #(
    parameter int DATA_W = 9,
    parameter int SEL_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [SEL_W-1:0]         sel,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [DATA_W-1:0] y
);
    localparam int MAXLOG = 1 << SEL_W;
    localparam int DEPTH  = 1 << MAXLOG;
    localparam int SUM_W  = DATA_W + MAXLOG;
    localparam int MAXV   = (1 << (DATA_W - 1)) - 1;

    logic signed [DATA_W-1:0] hist [DEPTH-1];
    logic signed [SUM_W-1:0]  term [DEPTH];
    logic signed [SUM_W-1:0]  sum;
    logic [MAXLOG:0]          len;

    assign len = (MAXLOG+1)'(2) << sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_term
        if (g == 0) begin : g_new
            assign term[g] = {{MAXLOG{x[DATA_W-1]}}, x};
        end else begin : g_old
            assign term[g] = (g < int'(len)) ? {{MAXLOG{hist[g-1][DATA_W-1]}}, hist[g-1]} : '0;
        end
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sum = sum + term[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0;
            for (int i = 0; i < DEPTH - 1; i++) hist[i] <= '0;
        end else if (push) begin
            y       <= DATA_W'(sum >>> (int'(sel) + 1));
            hist[0] <= x;
            for (int i = 1; i < DEPTH - 1; i++) hist[i] <= hist[i-1];
        end
    end

    assert_avg_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (y <= DATA_W'(MAXV)) && (y >= -DATA_W'(MAXV)));

    assert_avg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(y));
endmodule

// File: rtl/qdm_ctrl.sv
module qdm_ctrl
    import qdm_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] sel,
    output logic             out_valid
);
    localparam int MAXLOG = 1 << SEL_W;
    localparam int CW     = MAXLOG + 1;
    localparam logic [CW-1:0] DEPTH = CW'(1) << MAXLOG;

    qdm_state_e       state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [SEL_W-1:0] sel_q;
    logic             restart;
    logic [CW-1:0]    base;
    logic [CW-1:0]    need;
    logic             full;

    always_comb begin
        restart = (sel != sel_q);
        base    = restart ? '0 : cnt_q;
        need    = CW'(2) << sel;
        full    = in_valid && ((base + CW'(1)) >= need);
        cnt_d   = base;
        if (in_valid && (base != DEPTH)) cnt_d = base + CW'(1);
        unique case (state_q)
            ST_FILL: state_d = full ? ST_RUN : ST_FILL;
            ST_RUN:  state_d = restart ? ST_FILL : ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= full;
        end
    end

    assert_valid_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_restart_blocks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !out_valid);

    assert_run_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (state_q == ST_RUN) || $past(restart));
endmodule

// File: rtl/chroma_qdemod.sv
module chroma_qdemod #(
    parameter int DATA_W = 9,
    parameter int ACC_W  = 24,
    parameter int LUT_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_chroma,
    input  logic [ACC_W-1:0]         phase_inc,
    input  logic [SEL_W-1:0]         lpf_sel,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_u,
    output logic signed [DATA_W-1:0] out_v
);
    logic signed [DATA_W-1:0] car_i, car_q;
    logic signed [DATA_W-1:0] mix_u, mix_v;

    qdm_dto #(.ACC_W(ACC_W), .LUT_W(LUT_W), .DATA_W(DATA_W)) i_dto (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .inc(phase_inc),
        .car_i(car_i), .car_q(car_q)
    );

    qdm_mix #(.DATA_W(DATA_W)) i_mix_u (.x(in_chroma), .c(car_i), .y(mix_u));
    qdm_mix #(.DATA_W(DATA_W)) i_mix_v (.x(in_chroma), .c(car_q), .y(mix_v));

    qdm_avg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_avg_u (
        .clk(clk), .rst_n(rst_n), .push(in_valid), .sel(lpf_sel), .x(mix_u), .y(out_u)
    );
    qdm_avg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_avg_v (
        .clk(clk), .rst_n(rst_n), .push(in_valid), .sel(lpf_sel), .x(mix_v), .y(out_v)
    );

    qdm_ctrl #(.SEL_W(SEL_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel(lpf_sel), .out_valid(out_valid)
    );
endmodule

// File: tb/test_chroma_qdemod.sv
module test_chroma_qdemod;
    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic signed [8:0] in_chroma;
    logic [23:0]       phase_inc;
    logic [1:0]        lpf_sel;
    logic              out_valid;
    logic signed [8:0] out_u, out_v;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int m_acc, m_selq, m_cnt, e_u, e_v, seed;
    bit e_valid;
    int hu[$];
    int hv[$];

    always #5 clk = ~clk;

    chroma_qdemod i_chroma_qdemod (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chroma(in_chroma),
        .phase_inc(phase_inc), .lpf_sel(lpf_sel), .out_valid(out_valid),
        .out_u(out_u), .out_v(out_v)
    );

    function automatic int carrier(input int a);
        int aa = a % 256;
        int k  = aa % 128;
        int m  = (k * (128 - k) * 255) / 4096;
        return (aa >= 128) ? -m : m;
    endfunction

    function automatic int mixr(input int x, input int c);
        int r = (x * c + 128) >>> 8;
        if (r > 255) r = 255;
        if (r < -255) r = -255;
        return r;
    endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fffff;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_acc = 0; m_selq = 0; m_cnt = 0; e_u = 0; e_v = 0; e_valid = 1'b0;
        hu.delete(); hv.delete();
        for (int i = 0; i < 16; i++) begin hu.push_back(0); hv.push_back(0); end
    endtask

    task automatic cyc(input bit v, input int x, input int inc, input int sel, input string tag);
        bit restart;
        int base, n, su, sv;
        in_valid  = v;
        in_chroma = 9'(x);
        phase_inc = 24'(inc);
        lpf_sel   = 2'(sel);
        restart = (sel != m_selq);
        base    = restart ? 0 : m_cnt;
        n       = 2 << sel;
        e_valid = v && (base + 1 >= n);
        if (v) begin
            int a = (m_acc >> 16) & 255;
            hu.push_front(mixr(x, carrier(a + 64)));
            hv.push_front(mixr(x, carrier(a)));
            void'(hu.pop_back()); void'(hv.pop_back());
            su = 0; sv = 0;
            for (int i = 0; i < n; i++) begin su += hu[i]; sv += hv[i]; end
            e_u = su >>> (sel + 1);
            e_v = sv >>> (sel + 1);
            m_acc = (m_acc + inc) & 32'hFFFFFF;
            m_cnt = (base + 1 > 16) ? 16 : base + 1;
        end else begin
            m_cnt = base;
        end
        m_selq = sel;
        @(negedge clk);
        check({tag, " valid"}, int'(out_valid), int'(e_valid));
        check({tag, " u"}, int'(out_u), e_u);
        check({tag, " v"}, int'(out_v), e_v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        seed = 7;
        rst_n = 1'b0; in_valid = 1'b0; in_chroma = '0; phase_inc = '0; lpf_sel = '0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 valid", int'(out_valid), 0);
        check("R1 u", int'(out_u), 0);
        check("R1 v", int'(out_v), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post valid", int'(out_valid), 0);
        check("R1 post u", int'(out_u), 0);

        // R3/R4: fixed phase 0, in-phase carrier 255, quadrature 0
        for (int i = 0; i < 4; i++) cyc(1, 100, 0, 0, "R4 fixed");
        check("R4 u fixed", int'(out_u), 100);
        check("R4 v fixed", int'(out_v), 0);

        // R2: one address step per sample
        for (int i = 0; i < 300; i++) cyc(1, 255, 32'h10000, 0, "R2 step");
        // R3: random increments, full-scale negative input
        for (int i = 0; i < 300; i++) cyc(1, -256, rnd() & 32'hFFFFFF, 1, "R3 sweep");
        // R4: alternating extremes
        for (int i = 0; i < 200; i++) cyc(1, (i % 2) ? 255 : -256, 32'h3F0000, 0, "R4 extreme");

        // R5: each window length with random samples
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 60; i++)
                cyc(1, (rnd() % 512) - 256, rnd() & 32'hFFFFFF, s, "R5 window");

        // R6/R9: fill after a select change to the longest window
        for (int i = 0; i < 20; i++) cyc(1, (rnd() % 512) - 256, 32'h123456, 2, "R9 fill");
        for (int i = 0; i < 20; i++) cyc(1, (rnd() % 512) - 256, 32'h123456, 3, "R6 fill");

        // R7: select change with and without a sample in the same cycle
        cyc(1, 50, 32'h222222, 0, "R7 change with sample");
        cyc(1, 60, 32'h222222, 0, "R7 second");
        cyc(0, 0, 32'h222222, 1, "R7 change idle");
        for (int i = 0; i < 6; i++) cyc(1, (rnd() % 512) - 256, 32'h222222, 1, "R7 refill");

        // R8: gapped valid
        for (int i = 0; i < 200; i++)
            cyc((rnd() % 3) != 0, (rnd() % 512) - 256, rnd() & 32'hFFFFFF, (i / 50) % 4, "R8 gaps");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule